// File: doc/BRIEF.md
# I2C Register Interface for a 16-bit GPIO Expander

This block is the serial front end and register bank of a two-port, 16-pin general-purpose I/O expander. A bus master addresses the block over I2C, sends a command byte whose low nibble selects one of sixteen byte-wide locations, and then either writes data bytes into the bank or, after a repeated START with the read bit set, reads bytes back. The location pointer advances after every byte in either direction, so a master can sweep several registers in one transaction.

The bank holds the live, synchronized pin levels for each port, an output value byte and a direction byte per port (both brought out to the pad logic), a per-port interrupt mask, and a per-port latched change status. A status bit latches when an unmasked pin differs from the value that was last returned by a read of that port's input register. Reading a status register clears it. The open-drain interrupt output is active low. The block oversamples SCL and SDA with its own clock and drives SDA as a low-going enable only.

Top module: `gpio_i2c_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the DEV_ADDR parameter (default 7'h20). A mismatch leaves SDA undriven until the next START, and bit 0 of the address byte selects read (1) or write (0).
- R2: In a write transaction, every byte after the command byte is acknowledged and stored at the current pointer when the SCL falls to end that byte's acknowledge clock. The pointer then advances by one.
- R3: In a read transaction (command byte, repeated START, address with bit 0 set), the first returned byte is the location named by the command byte, MSB first. Each master ACK returns the next location.
- R4: Only command bits [3:0] select the location; bits [7:4] are ignored. The pointer wraps from 0Fh to 00h.
- R5: Locations 00h and 01h return the two-flop-synchronized levels of pins 7:0 and 15:8. Writes to them are acknowledged and change nothing.
- R6: Locations 02h/03h hold out_val[7:0]/[15:8] and 04h/05h hold dir_cfg[7:0]/[15:8]. All reset to 00h, are read back as written, and change only on a write to their own location.
- R7: Locations 0Ch/0Dh are the port 0/port 1 interrupt masks. They are read/write, reset to FFh, and a mask bit at 1 blocks that pin from setting status.
- R8: Locations 0Eh/0Fh are read-only status for port 0/port 1. A bit sets while its pin is unmasked and differs from the reference byte, which resets to 00h and is reloaded from the pins each time that port's input location is read. Reading a status location returns it and then clears it, and writes to it are ignored.
- R9: int_n is low exactly while any status bit is set.
- R10: Locations 06h to 0Bh read as 00h. Writes to them are acknowledged and ignored.
- R11: A master NACK on a read byte releases SDA and ends the transfer. A STOP at any point, including mid-byte, returns the block to idle with no partial write.
- R12: After reset, sda_oe is 0, int_n is 1, and out_val and dir_cfg are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pins_i | input | 16 | Raw pin levels, port 1 in [15:8] |
| out_val | output | 16 | Output value bytes for the pad drivers |
| dir_cfg | output | 16 | Direction bytes for the pad drivers |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The bench drives the bus at the bit level. Single-byte and multi-byte writes and reads show whether the pointer advances, and a command with a nonzero upper nibble shows whether those bits are dropped. A four-byte read starting at 0Dh crosses the wrap point. A sixteen-byte sweep tells apart real registers, reserved locations that must read zero, and input locations that ignored the writes. Pin changes on a masked and on an unmasked port, interleaved with input and status reads, separate the set, hold and clear behaviour of the status latch. A wrong address, a STOP in the middle of a data byte, and a closing NACK confirm that nothing is written and that SDA is released.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;
   localparam int PORT_W = 8;
   localparam int NPORT  = 2;
   localparam int IDX_W  = 4;
   localparam int PINS_W = PORT_W * NPORT;

   // per-port base locations; port p sits at base + p
   localparam int LOC_IN   = 0;
   localparam int LOC_OUT  = 2;
   localparam int LOC_DIR  = 4;
   localparam int LOC_MASK = 12;
   localparam int LOC_STAT = 14;

   typedef enum logic [2:0] {
      LNK_IDLE,
      LNK_ADDR,
      LNK_CMD,
      LNK_WR,
      LNK_RD
   } link_state_t;
endpackage

// File: rtl/gpio_exp_sync.sv
module gpio_exp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter bit RST    = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= {W{RST}};
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_exp_link.sv
module gpio_exp_link
   import gpio_exp_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             rd_en,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_oe,
   output logic             start_seen,
   output logic             link_idle
);
   link_state_t      st;
   logic [3:0]       bcnt;
   logic [7:0]       shin;
   logic [7:0]       shout;
   logic [IDX_W-1:0] ptr;
   logic             mst_ack;
   logic             scl_p, sda_p;
   logic             rise, fall, stop_c, ack_end;

   assign rise       = scl_s & ~scl_p;
   assign fall       = ~scl_s & scl_p;
   assign start_seen = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_c     = scl_s & scl_p & ~sda_p & sda_s;
   assign ack_end    = fall && (bcnt == 4'd9) && (st != LNK_IDLE);

   assign rd_en   = ack_end && (((st == LNK_ADDR) && shin[0]) || ((st == LNK_RD) && mst_ack));
   assign rd_idx  = (st == LNK_RD) ? ptr + 1'b1 : ptr;
   assign wr_en   = ack_end && (st == LNK_WR);
   assign wr_idx  = ptr;
   assign wr_data = shin;
   assign link_idle = (st == LNK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LNK_IDLE;
         bcnt    <= '0;
         shin    <= '0;
         shout   <= '0;
         ptr     <= '0;
         mst_ack <= 1'b0;
         sda_oe  <= 1'b0;
         scl_p   <= 1'b1;
         sda_p   <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (stop_c) begin
            st     <= LNK_IDLE;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (start_seen) begin
            st     <= LNK_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (st != LNK_IDLE) begin
            if (rise) begin
               if (bcnt < 4'd8) begin
                  shin <= {shin[6:0], sda_s};
                  bcnt <= bcnt + 1'b1;
               end else begin
                  bcnt    <= 4'd9;
                  mst_ack <= ~sda_s;
               end
            end else if (fall) begin
               if (bcnt == 4'd8) begin
                  unique case (st)
                     LNK_ADDR: if (shin[7:1] == DEV_ADDR) sda_oe <= 1'b1;
                               else st <= LNK_IDLE;
                     LNK_RD:   sda_oe <= 1'b0;
                     default:  sda_oe <= 1'b1;
                  endcase
               end else if (bcnt == 4'd9) begin
                  bcnt   <= '0;
                  sda_oe <= 1'b0;
                  unique case (st)
                     LNK_ADDR: begin
                        if (shin[0]) begin
                           st     <= LNK_RD;
                           sda_oe <= ~rd_data[7];
                           shout  <= {rd_data[6:0], 1'b0};
                        end else begin
                           st <= LNK_CMD;
                        end
                     end
                     LNK_CMD: begin
                        ptr <= shin[IDX_W-1:0];
                        st  <= LNK_WR;
                     end
                     LNK_WR: ptr <= ptr + 1'b1;
                     LNK_RD: begin
                        if (mst_ack) begin
                           ptr    <= ptr + 1'b1;
                           sda_oe <= ~rd_data[7];
                           shout  <= {rd_data[6:0], 1'b0};
                        end else begin
                           st <= LNK_IDLE;
                        end
                     end
                     default: st <= LNK_IDLE;
                  endcase
               end else if (st == LNK_RD && bcnt != 4'd0) begin
                  sda_oe <= ~shout[7];
                  shout  <= {shout[6:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/gpio_exp_regs.sv
module gpio_exp_regs
   import gpio_exp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS_W-1:0] pins_s,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data,
   output logic [PINS_W-1:0] out_val,
   output logic [PINS_W-1:0] dir_cfg,
   output logic [PINS_W-1:0] mask_all,
   output logic [PINS_W-1:0] stat_all,
   output logic              int_n
);
   logic [NPORT-1:0][PORT_W-1:0] in_v, out_v, dir_v, msk_v, sts_v;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [PORT_W-1:0] out_q, dir_q, msk_q, sts_q, ref_q, pin_w, chg_w;
      logic hit_out, hit_dir, hit_msk, take_sts, take_in;

      assign pin_w    = pins_s[p*PORT_W +: PORT_W];
      assign hit_out  = wr_en && (wr_idx == IDX_W'(LOC_OUT + p));
      assign hit_dir  = wr_en && (wr_idx == IDX_W'(LOC_DIR + p));
      assign hit_msk  = wr_en && (wr_idx == IDX_W'(LOC_MASK + p));
      assign take_sts = rd_en && (rd_idx == IDX_W'(LOC_STAT + p));
      assign take_in  = rd_en && (rd_idx == IDX_W'(LOC_IN + p));
      assign chg_w    = ~msk_q & (pin_w ^ ref_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            msk_q <= '1;
            sts_q <= '0;
            ref_q <= '0;
         end else begin
            if (hit_out) out_q <= wr_data;
            if (hit_dir) dir_q <= wr_data;
            if (hit_msk) msk_q <= wr_data;
            if (take_in) ref_q <= pin_w;
            sts_q <= (take_sts ? '0 : sts_q) | chg_w;
         end
      end

      assign in_v[p]  = pin_w;
      assign out_v[p] = out_q;
      assign dir_v[p] = dir_q;
      assign msk_v[p] = msk_q;
      assign sts_v[p] = sts_q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NPORT; k++) begin
         if (rd_idx == IDX_W'(LOC_IN + k))   rd_data = in_v[k];
         if (rd_idx == IDX_W'(LOC_OUT + k))  rd_data = out_v[k];
         if (rd_idx == IDX_W'(LOC_DIR + k))  rd_data = dir_v[k];
         if (rd_idx == IDX_W'(LOC_MASK + k)) rd_data = msk_v[k];
         if (rd_idx == IDX_W'(LOC_STAT + k)) rd_data = sts_v[k];
      end
   end

   assign out_val  = out_v;
   assign dir_cfg  = dir_v;
   assign mask_all = msk_v;
   assign stat_all = sts_v;
   assign int_n    = ~|sts_v;
endmodule

// File: rtl/gpio_i2c_expander.sv
module gpio_i2c_expander
   import gpio_exp_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h20,
   parameter int         BUS_STAGES  = 2,
   parameter int         PIN_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [PINS_W-1:0] pins_i,
   output logic [PINS_W-1:0] out_val,
   output logic [PINS_W-1:0] dir_cfg,
   output logic              int_n
);
   if (BUS_STAGES < 2) begin : g_bad_bus
      $error("BUS_STAGES must be at least 2");
   end
   if (PIN_STAGES < 2) begin : g_bad_pin
      $error("PIN_STAGES must be at least 2");
   end
   if (NPORT * 4 > (1 << IDX_W)) begin : g_bad_map
      $error("register map does not fit the index width");
   end

   logic [1:0]        bus_s;
   logic [PINS_W-1:0] pins_s;
   logic [7:0]        rd_data, wr_data;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic              rd_en, wr_en, start_seen, link_idle;
   logic [PINS_W-1:0] mask_all, stat_all;

   gpio_exp_sync #(.W(2), .STAGES(BUS_STAGES), .RST(1'b1)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );

   gpio_exp_sync #(.W(PINS_W), .STAGES(PIN_STAGES), .RST(1'b0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_i), .q(pins_s)
   );

   gpio_exp_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk(clk), .rst_n(rst_n),
      .scl_s(bus_s[1]), .sda_s(bus_s[0]),
      .rd_data(rd_data), .rd_idx(rd_idx), .rd_en(rd_en),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_oe(sda_oe), .start_seen(start_seen), .link_idle(link_idle)
   );

   gpio_exp_regs u_regs (
      .clk(clk), .rst_n(rst_n), .pins_s(pins_s),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .out_val(out_val), .dir_cfg(dir_cfg),
      .mask_all(mask_all), .stat_all(stat_all), .int_n(int_n)
   );
endmodule

// File: rtl/gpio_exp_chk.sv
module gpio_exp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sda_oe,
   input logic [15:0] out_val,
   input logic [15:0] dir_cfg,
   input logic        wr_en,
   input logic [3:0]  wr_idx,
   input logic [15:0] mask_all,
   input logic [15:0] stat_all,
   input logic        start_seen,
   input logic        link_idle
);
   p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |=> !sda_oe);

   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wr_idx == 4'($past(wr_idx) + 4'd1)));

   p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(out_val) && $stable(dir_cfg)));

   p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx[3:1] == 3'b110) |=> $stable(mask_all));

   p_set_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_all & ~$past(stat_all) & $past(mask_all)) == 16'h0000));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      link_idle |-> !sda_oe);
endmodule

bind gpio_i2c_expander gpio_exp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe),
   .out_val(out_val), .dir_cfg(dir_cfg),
   .wr_en(wr_en), .wr_idx(wr_idx),
   .mask_all(mask_all), .stat_all(stat_all),
   .start_seen(start_seen), .link_idle(link_idle)
);

// File: tb/gpio_i2c_expander_test.sv
module gpio_i2c_expander_test;
   localparam int         Q    = 10;
   localparam logic [6:0] ADDR = 7'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [15:0] pins = 16'h0000;
   wire         sda_oe, int_n;
   wire  [15:0] out_val, dir_cfg;
   wire         sda_line = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   gpio_i2c_expander uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .pins_i(pins), .out_val(out_val),
      .dir_cfg(dir_cfg), .int_n(int_n)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   logic [7:0] m_out [2];
   logic [7:0] m_dir [2];
   logic [7:0] m_msk [2];
   logic [7:0] m_sts [2];
   logic [7:0] m_ref [2];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // reference model compared on every clock while the bus is quiet
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R6 out_val", {16'h0, out_val}, {16'h0, m_out[1], m_out[0]});
         chk("R6 dir_cfg", {16'h0, dir_cfg}, {16'h0, m_dir[1], m_dir[0]});
         chk("R9 int_n", {31'h0, int_n}, {31'h0, (m_sts[0] == 8'h00 && m_sts[1] == 8'h00)});
      end
   end

   function automatic void model_write(input logic [3:0] idx, input logic [7:0] v);
      case (idx)
         4'h2: m_out[0] = v;
         4'h3: m_out[1] = v;
         4'h4: m_dir[0] = v;
         4'h5: m_dir[1] = v;
         4'hC: m_msk[0] = v;
         4'hD: m_msk[1] = v;
         default: ;
      endcase
   endfunction

   function automatic logic [7:0] model_read(input logic [3:0] idx);
      logic [7:0] v;
      v = 8'h00;
      case (idx)
         4'h0: begin v = pins[7:0];  m_ref[0] = v; end
         4'h1: begin v = pins[15:8]; m_ref[1] = v; end
         4'h2: v = m_out[0];
         4'h3: v = m_out[1];
         4'h4: v = m_dir[0];
         4'h5: v = m_dir[1];
         4'hC: v = m_msk[0];
         4'hD: v = m_msk[1];
         4'hE: begin v = m_sts[0]; m_sts[0] = 8'h00; end
         4'hF: begin v = m_sts[1]; m_sts[1] = 8'h00; end
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic settle();
      repeat (12) @(negedge clk);
      m_sts[0] = m_sts[0] | (~m_msk[0] & (pins[7:0]  ^ m_ref[0]));
      m_sts[1] = m_sts[1] | (~m_msk[1] & (pins[15:8] ^ m_ref[1]));
      cmp_on = 1'b1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      ack = ~sda_line;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         scl_m = 1'b1; wq();
         b[i] = sda_line;
         wq();
         scl_m = 1'b0;
      end
      sda_m = ~give_ack; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic wr_txn(input logic [7:0] cmd, input int n, input logic [63:0] data);
      logic       a;
      logic [3:0] ptr;
      cmp_on = 1'b0;
      bus_start();
      wbyte({ADDR, 1'b0}, a);
      chk("R1 address ack on write", {31'h0, a}, 32'h1);
      wbyte(cmd, a);
      chk("R2 command ack", {31'h0, a}, 32'h1);
      ptr = cmd[3:0];
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = data[8*(n-1-i) +: 8];
         wbyte(b, a);
         chk("R2 data ack (R5 R10 included)", {31'h0, a}, 32'h1);
         model_write(ptr, b);
         ptr = ptr + 4'd1;
      end
      bus_stop();
      settle();
   endtask

   task automatic rd_txn(input logic [7:0] cmd, input int n, input string tag);
      logic       a;
      logic [3:0] ptr;
      logic [7:0] b;
      cmp_on = 1'b0;
      bus_start();
      wbyte({ADDR, 1'b0}, a);
      chk("R1 address ack before read", {31'h0, a}, 32'h1);
      wbyte(cmd, a);
      chk("R3 command ack", {31'h0, a}, 32'h1);
      bus_start();
      wbyte({ADDR, 1'b1}, a);
      chk("R3 read address ack", {31'h0, a}, 32'h1);
      ptr = cmd[3:0];
      for (int i = 0; i < n; i++) begin
         rbyte(i != n - 1, b);
         chk(tag, {24'h0, b}, {24'h0, model_read(ptr)});
         ptr = ptr + 4'd1;
      end
      chk("R11 SDA released after NACK", {31'h0, sda_oe}, 32'h0);
      bus_stop();
      settle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R11 actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic a;
      for (int p = 0; p < 2; p++) begin
         m_out[p] = 8'h00; m_dir[p] = 8'h00; m_msk[p] = 8'hFF;
         m_sts[p] = 8'h00; m_ref[p] = 8'h00;
      end
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R12 sda_oe after reset", {31'h0, sda_oe}, 32'h0);
      chk("R12 int_n after reset", {31'h0, int_n}, 32'h1);
      chk("R12 out_val after reset", {16'h0, out_val}, 32'h0);
      chk("R12 dir_cfg after reset", {16'h0, dir_cfg}, 32'h0);
      settle();

      // R2 R6: burst write of outputs and directions, R3 burst read back
      wr_txn(8'h02, 4, 64'hA53CF00F);
      rd_txn(8'h02, 4, "R3 burst read of control bytes");

      // R5: input locations follow pins and ignore writes
      cmp_on = 1'b0;
      pins = 16'h1234;
      settle();
      wr_txn(8'h00, 2, 64'hFFFF);
      rd_txn(8'h00, 2, "R5 input locations");

      // R4: upper command nibble ignored, wrap 0Fh to 00h
      wr_txn(8'hF3, 1, 64'h5A);
      rd_txn(8'h03, 1, "R4 high nibble ignored");
      rd_txn(8'h3D, 4, "R4 wrap across 0Fh");

      // R10: reserved locations
      wr_txn(8'h06, 6, 64'h112233445566);
      rd_txn(8'h00, 16, "R10 full sweep");

      // R7 R8 R9: interrupt path
      wr_txn(8'h0C, 1, 64'h00);
      cmp_on = 1'b0;
      pins = 16'h1235;
      settle();
      chk("R9 int_n low on unmasked change", {31'h0, int_n}, 32'h0);
      cmp_on = 1'b0;
      pins = 16'h9235;
      settle();
      rd_txn(8'h0F, 1, "R7 masked port sets no status");
      rd_txn(8'h0E, 1, "R8 status while cause persists");
      rd_txn(8'h00, 1, "R5 input read reloads reference");
      rd_txn(8'h0E, 1, "R8 latched status");
      rd_txn(8'h0E, 1, "R8 status cleared by read");
      chk("R9 int_n high when clear", {31'h0, int_n}, 32'h1);
      wr_txn(8'h0E, 2, 64'hFFFF);
      rd_txn(8'h0E, 2, "R8 status ignores writes");
      wr_txn(8'h0D, 1, 64'h00);
      rd_txn(8'h0F, 1, "R8 port 1 status after unmask");
      rd_txn(8'h0C, 2, "R7 mask read back");

      // R1: foreign address
      cmp_on = 1'b0;
      bus_start();
      wbyte({7'h21, 1'b0}, a);
      chk("R1 foreign address not acked", {31'h0, a}, 32'h0);
      wbyte(8'h02, a);
      chk("R1 no ack after mismatch", {31'h0, a}, 32'h0);
      wbyte(8'h77, a);
      bus_stop();
      settle();

      // R11: STOP in the middle of a data byte
      cmp_on = 1'b0;
      bus_start();
      wbyte({ADDR, 1'b0}, a);
      wbyte(8'h02, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop();
      settle();
      rd_txn(8'h02, 2, "R11 no partial write and recovery");

      repeat (20) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule